// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets logic running on a single clock read and write one byte of an external asynchronous static RAM with a 17-bit address and an 8-bit shared data bus. A request carries an address, a write byte, a direction flag and a valid strobe. The controller answers with a busy flag while the access is in progress. When the access ends it gives a one-cycle done pulse, and after a read it also presents the read byte.

On the memory side every pin comes from a flop. Each access passes through four timed phases: setup, active, hold and done. Their lengths are parameters counted in clock cycles. In a write, the address is set up, the write strobe is pulsed with the address held still, and then the data is held after the strobe rises. In a read, output enable is driven low together with chip enable, and the byte is captured at the end of the access window. The data bus is split into an output value, a driver enable and an input value, so that the tri-state buffer can sit at the pad. The driver is on only in write phases, and it is always off at least one cycle before output enable falls.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_cs and mem_dq_oe are 0, and busy and rsp_done are 0.
- R2: With no access in progress the memory is deselected (mem_ce_n=1, mem_cs=0). Through every phase of an access it is selected (mem_ce_n=0, mem_cs=1).
- R3: A read holds mem_we_n=1 and mem_oe_n=0 from the cycle the address is applied. The byte on mem_dq_in is captured SETUP_CYC+ACCESS_CYC cycles after the address changes and appears on rsp_rdata with the done pulse.
- R4: A write drives the data with mem_we_n=1 for exactly SETUP_CYC cycles, then holds mem_we_n=0 for exactly PULSE_CYC cycles, then keeps the same data driven with mem_we_n=1 for exactly HOLD_CYC cycles. The byte stored is the one driven at the rising edge of mem_we_n.
- R5: mem_addr does not change while mem_we_n is low.
- R6: mem_dq_oe is 1 only in write phases, and mem_oe_n is 1 in every cycle where mem_dq_oe is 1, so the controller and the memory never drive the bus together.
- R7: mem_oe_n falls only when mem_dq_oe was 0 in the previous cycle.
- R8: busy is 1 from the cycle after acceptance until the done cycle. A req_valid that arrives while busy is 1 is ignored: it causes no memory write and no extra done pulse.
- R9: rsp_done is high for exactly one cycle per accepted request. It appears SETUP_CYC+ACCESS_CYC+HOLD_CYC+1 cycles after acceptance for a read, and SETUP_CYC+PULSE_CYC+HOLD_CYC+1 cycles after acceptance for a write.
- R10: mem_we_n is low only while mem_ce_n=0 and mem_cs=1.
- R11: rsp_rdata keeps the last read byte and is not changed by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_rdata | output | DATA_W | Last byte read |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access in progress |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Value for the data pad driver |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | DATA_W | Value seen on the data pad |

## Verification
The memory model in the bench returns a garbage byte until the address has been stable with output enable low for the full access window. A read that samples even one cycle early therefore returns the wrong byte. The model also measures how long data is driven around each write strobe. A controller that shortens the setup or hold window, or that lets the data change before the strobe rises, records a wrong length or stores the wrong byte. The model counts cycles in which both sides drive the bus, address changes under a low write strobe, and output enable falling right after the driver was on. A controller that sequences output enable carelessly leaves one of these counts above zero. A second request sent in mid-write tests that requests are ignored while busy: if the controller latched it, a later read of that address shows a stored byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_DONE   = 3'd4
   } phase_e;

   typedef struct packed {
      logic ce_n;
      logic cs;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } pin_ctl_t;

   localparam pin_ctl_t PINS_PARKED = '{ce_n: 1'b1, cs: 1'b0, we_n: 1'b1,
                                         oe_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/asram_phase_fsm.sv
module asram_phase_fsm
   import asram_pkg::*;
#(
   parameter int SETUP_CYC  = 1,
   parameter int ACCESS_CYC = 3,
   parameter int PULSE_CYC  = 2,
   parameter int HOLD_CYC   = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   is_write,
   output phase_e phase_q,
   output phase_e phase_nxt,
   output logic   last_active
);

   localparam int MAX_AP  = (ACCESS_CYC > PULSE_CYC) ? ACCESS_CYC : PULSE_CYC;
   localparam int MAX_SH  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int MAX_ALL = (MAX_AP > MAX_SH) ? MAX_AP : MAX_SH;
   localparam int CNT_W   = (MAX_ALL > 1) ? $clog2(MAX_ALL) : 1;

   if (SETUP_CYC < 1)  begin : g_chk_setup  $error("SETUP_CYC must be at least 1");  end
   if (ACCESS_CYC < 1) begin : g_chk_access $error("ACCESS_CYC must be at least 1"); end
   if (PULSE_CYC < 1)  begin : g_chk_pulse  $error("PULSE_CYC must be at least 1");  end
   if (HOLD_CYC < 1)   begin : g_chk_hold   $error("HOLD_CYC must be at least 1");   end

   logic [CNT_W-1:0] cnt_q, cnt_nxt, active_load;

   if (ACCESS_CYC == PULSE_CYC) begin : g_load_shared
      assign active_load = CNT_W'(ACCESS_CYC - 1);
   end else begin : g_load_split
      assign active_load = is_write ? CNT_W'(PULSE_CYC - 1) : CNT_W'(ACCESS_CYC - 1);
   end

   always_comb begin
      phase_nxt = phase_q;
      cnt_nxt   = cnt_q;
      unique case (phase_q)
         PH_IDLE: if (start) begin
            phase_nxt = PH_SETUP;
            cnt_nxt   = CNT_W'(SETUP_CYC - 1);
         end
         PH_SETUP: if (cnt_q == '0) begin
            phase_nxt = PH_ACTIVE;
            cnt_nxt   = active_load;
         end else cnt_nxt = cnt_q - 1'b1;
         PH_ACTIVE: if (cnt_q == '0) begin
            phase_nxt = PH_HOLD;
            cnt_nxt   = CNT_W'(HOLD_CYC - 1);
         end else cnt_nxt = cnt_q - 1'b1;
         PH_HOLD: if (cnt_q == '0) phase_nxt = PH_DONE;
                  else cnt_nxt = cnt_q - 1'b1;
         PH_DONE: phase_nxt = PH_IDLE;
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_nxt;
         cnt_q   <= cnt_nxt;
      end
   end

   assign last_active = (phase_q == PH_ACTIVE) && (cnt_q == '0);

   // R9: once an access leaves idle it must reach the done phase
   assert_done_follows_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD && cnt_q == '0) |=> (phase_q == PH_DONE));

endmodule

// File: rtl/asram_pin_ctl.sv
module asram_pin_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_nxt,
   input  logic              wr_nxt,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output pin_ctl_t          pins_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   function automatic pin_ctl_t decode_pins(phase_e ph, logic wr);
      pin_ctl_t p;
      p = PINS_PARKED;
      unique case (ph)
         PH_SETUP: begin
            p.ce_n = 1'b0; p.cs = 1'b1;
            p.oe_n = wr;   p.dq_oe = wr;
         end
         PH_ACTIVE: begin
            p.ce_n = 1'b0; p.cs = 1'b1;
            p.oe_n = wr;   p.dq_oe = wr; p.we_n = ~wr;
         end
         PH_HOLD: begin
            p.ce_n = 1'b0; p.cs = 1'b1;
            p.dq_oe = wr;
         end
         default: p = PINS_PARKED;
      endcase
      return p;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q  <= PINS_PARKED;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         pins_q <= decode_pins(phase_nxt, wr_nxt);
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= dq_in;
      end
   end

   assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pins_q.dq_oe |-> pins_q.oe_n);

   assert_release_before_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pins_q.oe_n) |-> !$past(pins_q.dq_oe));

   assert_we_only_selected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pins_q.we_n |-> (!pins_q.ce_n && pins_q.cs));

   assert_addr_still_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_q.we_n && $past(!pins_q.we_n)) |-> $stable(addr_q));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int SETUP_CYC  = 1,
   parameter int ACCESS_CYC = 3,
   parameter int PULSE_CYC  = 2,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_chk_width
      $error("ADDR_W and DATA_W must be positive");
   end

   phase_e   phase_q, phase_nxt;
   pin_ctl_t pins_q;
   logic     accept, wr_q, wr_nxt, last_active, capture;

   assign accept = req_valid && (phase_q == PH_IDLE);
   assign wr_nxt = accept ? req_write : wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_q <= 1'b0;
      else if (accept) wr_q <= req_write;
   end

   asram_phase_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .ACCESS_CYC(ACCESS_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .is_write   (wr_q),
      .phase_q    (phase_q),
      .phase_nxt  (phase_nxt),
      .last_active(last_active)
   );

   assign capture = last_active && !wr_q;

   asram_pin_ctl #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_nxt(phase_nxt),
      .wr_nxt   (wr_nxt),
      .accept   (accept),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .capture  (capture),
      .dq_in    (mem_dq_in),
      .pins_q   (pins_q),
      .addr_q   (mem_addr),
      .wdata_q  (mem_dq_out),
      .rdata_q  (rsp_rdata)
   );

   assign mem_ce_n  = pins_q.ce_n;
   assign mem_cs    = pins_q.cs;
   assign mem_we_n  = pins_q.we_n;
   assign mem_oe_n  = pins_q.oe_n;
   assign mem_dq_oe = pins_q.dq_oe;
   assign busy      = (phase_q != PH_IDLE);
   assign rsp_done  = (phase_q == PH_DONE);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_busy_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_addr));

   assert_capture_while_reading_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (!mem_oe_n && mem_we_n && !mem_ce_n));

   assert_rdata_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> $stable(rsp_rdata));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int S  = 2;
   localparam int A  = 3;
   localparam int P  = 2;
   localparam int H  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic          rsp_done, busy, mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;

   always #4 clk = ~clk;

   asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .ACCESS_CYC(A),
                .PULSE_CYC(P), .HOLD_CYC(H)) u_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .busy(busy), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   int n_cmp = 0, n_bad = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [DW-1:0] model_mem [logic [AW-1:0]];
   logic [AW-1:0] prev_addr = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          prev_wlow = 1'b0, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, in_hold = 1'b0;
   int acc_run = 0, drv_run = 0, pulse_run = 0, hold_run = 0;
   int setup_seen = -1, pulse_seen = -1, hold_seen = -1;
   int contention = 0, addr_viol = 0, oe_viol = 0, we_viol = 0;

   function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
      return model_mem.exists(a) ? model_mem[a] : 8'h00;
   endfunction

   initial mem_dq_in = 'z;

   always @(negedge clk) begin
      logic sel, rd, wlow;
      sel  = !mem_ce_n && mem_cs;
      rd   = sel && mem_we_n && !mem_oe_n;
      wlow = sel && !mem_we_n;
      if (rd && mem_dq_oe) contention++;
      if (!mem_we_n && !sel) we_viol++;
      if (!mem_oe_n && prev_oe_n && prev_dq_oe) oe_viol++;
      if (wlow && prev_wlow && mem_addr != prev_addr) addr_viol++;
      if (rd) acc_run = (mem_addr == prev_addr) ? acc_run + 1 : 1;
      else    acc_run = 0;
      if (wlow) begin
         if (!prev_wlow) begin setup_seen = drv_run; pulse_run = 0; end
         pulse_run++;
         wr_addr = mem_addr;
         wr_data = mem_dq_out;
      end else if (prev_wlow) begin
         pulse_seen = pulse_run;
         model_mem[wr_addr] = mem_dq_out;
         hold_run = (mem_dq_oe && mem_dq_out == wr_data) ? 1 : 0;
         in_hold  = 1'b1;
      end else if (in_hold) begin
         if (mem_dq_oe && mem_dq_out == wr_data && mem_addr == wr_addr) hold_run++;
         else begin hold_seen = hold_run; in_hold = 1'b0; end
      end
      drv_run = (mem_dq_oe && mem_we_n && sel) ? drv_run + 1 : 0;
      mem_dq_in  = rd ? ((acc_run >= S + A) ? peek(mem_addr) : 8'hA5)
                      : (mem_dq_oe ? mem_dq_out : 'z);
      prev_addr  = mem_addr;
      prev_wlow  = wlow;
      prev_oe_n  = mem_oe_n;
      prev_dq_oe = mem_dq_oe;
   end

   // ---------------- access task ----------------
   task automatic do_acc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat);
      @(negedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk); #1;
      req_valid = 1'b0;
      lat = 1;
      check("R8 busy after accept", busy, 1);
      check("R2 selected in access", {mem_ce_n, mem_cs}, 2'b01);
      if (!wr) check("R3 read strobes", {mem_we_n, mem_oe_n}, 2'b10);
      while (!rsp_done && lat < 200) begin
         @(negedge clk); #1;
         lat++;
      end
      @(negedge clk); #1;
      check("R9 done one cycle", rsp_done, 0);
      check("R2 deselected idle", {mem_ce_n, mem_cs}, 2'b10);
   endtask

   // write flag, address, write byte, expected read byte
   localparam logic [33:0] VEC [10] = '{
      {1'b1, 17'h00000, 8'h55, 8'h00},
      {1'b1, 17'h1FFFF, 8'hAA, 8'h00},
      {1'b1, 17'h00123, 8'h3C, 8'h00},
      {1'b0, 17'h00000, 8'h00, 8'h55},
      {1'b0, 17'h1FFFF, 8'h00, 8'hAA},
      {1'b1, 17'h00123, 8'hC3, 8'h00},
      {1'b0, 17'h00123, 8'h00, 8'hC3},
      {1'b0, 17'h0ABCD, 8'h00, 8'h00},
      {1'b1, 17'h0ABCD, 8'hFF, 8'h00},
      {1'b0, 17'h0ABCD, 8'h00, 8'hFF}
   };

   bit finished = 0;

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      wrap_up();
   end

   initial begin
      int lat;
      logic [DW-1:0] keep;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 pins in reset", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
      check("R1 busy/done in reset", {busy, rsp_done}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 pins after reset", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

      foreach (VEC[i]) begin
         logic          w;
         logic [AW-1:0] a;
         logic [DW-1:0] d, e;
         {w, a, d, e} = VEC[i];
         do_acc(w, a, d, lat);
         if (w) begin
            check("R9 write latency", lat, S + P + H + 1);
            check("R4 setup cycles", setup_seen, S);
            check("R4 pulse cycles", pulse_seen, P);
            check("R4 hold cycles", hold_seen, H);
            check("R4 stored byte", peek(a), d);
         end else begin
            check("R9 read latency", lat, S + A + H + 1);
            check("R3 read data", rsp_rdata, e);
         end
      end

      // R11: a write leaves rsp_rdata alone
      keep = rsp_rdata;
      do_acc(1'b1, 17'h00042, 8'h9E, lat);
      check("R11 rdata after write", rsp_rdata, keep);

      // R8: request while busy ignored
      fork
         do_acc(1'b1, 17'h00777, 8'h12, lat);
         begin
            repeat (3) @(negedge clk);
            #2;
            req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00888; req_wdata = 8'h99;
            @(negedge clk); #2;
            req_valid = 1'b0;
         end
      join
      check("R8 busy request not stored", peek(17'h00888), 8'h00);
      repeat (2) @(negedge clk); #1;
      check("R8 no extra done", {busy, rsp_done}, 2'b00);
      do_acc(1'b0, 17'h00888, 8'h00, lat);
      check("R8 ignored address reads old", rsp_rdata, 8'h00);
      do_acc(1'b0, 17'h00777, 8'h00, lat);
      check("R3 read after busy test", rsp_rdata, 8'h12);

      check("R5 addr changes in pulse", addr_viol, 0);
      check("R6 bus contention cycles", contention, 0);
      check("R7 oe fall after driver", oe_viol, 0);
      check("R10 we while deselected", we_viol, 0);
      wrap_up();
   end

endmodule